// File: doc/BRIEF.md
# Double-Width Compare-and-Exchange Sequencer

This block carries out one 128-bit compare-and-exchange against memory as a read followed by a write. A caller gives an address, an expected value and a desired value, each as a pair of 64-bit halves, and chooses whether the sequence is locked. The block reads the location and compares the word it reads with the expected value. It then writes the location on every operation. On a match it writes the desired value. On a mismatch it writes the word it just read, so memory does not change.

When the caller asks for a lock, a bus lock output stays high from the read request through the write acknowledge, so the pair is atomic. Without the lock request the same read and write run with lock low. At the end the block gives a one-cycle completion pulse together with a success flag and the expected-value register pair. On a mismatch that register pair holds the observed memory word.

Top module: `dwcas_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `mem_rd_req`, `mem_wr_req` and `mem_lock` are all 0.
- R2: A request is taken only when `busy` is 0. A `req_valid` raised while an operation is running is ignored, so it causes no extra bus access and no write to its address.
- R3: The read comes first. `mem_rd_req` stays high until `mem_ack` arrives, and `mem_rd_req` and `mem_wr_req` are never high together.
- R4: If the word read equals `{exp_hi, exp_lo}` (high half in bits 127:64), the block writes `{des_hi, des_lo}` and `success` is 1.
- R5: If the word read differs, `success` is 0, the write data is the word that was read, and `exp_hi_q`/`exp_lo_q` return the high and low halves of that word.
- R6: Every accepted operation issues exactly one write to the request address, after its read. `mem_wr_req` stays high until `mem_ack` arrives.
- R7: In a locked operation, `mem_lock` is 1 in every cycle in which `mem_rd_req` or `mem_wr_req` is high, and it is 0 in the cycle after the write acknowledge.
- R8: In an unlocked operation `mem_lock` stays 0 the whole time. `mem_lock` is never 1 while `busy` is 0.
- R9: `done` is high for exactly one cycle per operation, and `busy` is also high in that cycle. `success`, `exp_hi_q` and `exp_lo_q` are valid while `done` is high.
- R10: Both halves take part in the compare. A difference in only the high half, or only the low half, makes the operation fail.
- R11: On success, `exp_hi_q`/`exp_lo_q` equal the expected value that was supplied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start an operation (taken when not busy) |
| req_lock | input | 1 | Hold the bus lock over the read/write pair |
| req_addr | input | ADDR_W | Target address |
| exp_lo | input | HALF_W | Expected value, low half |
| exp_hi | input | HALF_W | Expected value, high half |
| des_lo | input | HALF_W | Desired value, low half |
| des_hi | input | HALF_W | Desired value, high half |
| busy | output | 1 | Operation in progress, from acceptance through done |
| done | output | 1 | One-cycle completion pulse |
| success | output | 1 | Compare matched |
| exp_lo_q | output | HALF_W | Expected-value register, low half |
| exp_hi_q | output | HALF_W | Expected-value register, high half |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd_req | output | 1 | Read request, held until acknowledge |
| mem_wr_req | output | 1 | Write request, held until acknowledge |
| mem_wdata | output | 2*HALF_W | Write data |
| mem_rdata | input | 2*HALF_W | Read data, valid with acknowledge |
| mem_ack | input | 1 | Memory acknowledge |
| mem_lock | output | 1 | Bus lock |

## Verification
The assertions assume that the memory raises `mem_ack` only in a cycle that follows a cycle with a request already high, and only for one cycle per request. They also assume that `mem_rdata` is valid in the acknowledge cycle. The bench memory model meets these assumptions. It waits a random 1 to 3 cycles after it sees a request and then gives a one-cycle acknowledge, with read data taken from its own array. The stimulus raises `req_valid` while the block is busy only on purpose, to show that such a request is ignored.

// File: rtl/dwcas_pkg.sv
package dwcas_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_REQ  = 3'd1,
        ST_RD_WAIT = 3'd2,
        ST_CMP     = 3'd3,
        ST_WR_REQ  = 3'd4,
        ST_WR_WAIT = 3'd5,
        ST_DONE    = 3'd6
    } seq_state_e;

    function automatic logic in_read_phase(seq_state_e s);
        return (s == ST_RD_REQ) || (s == ST_RD_WAIT);
    endfunction

    function automatic logic in_write_phase(seq_state_e s);
        return (s == ST_WR_REQ) || (s == ST_WR_WAIT);
    endfunction

endpackage

// File: rtl/dwcas_fsm.sv
module dwcas_fsm
    import dwcas_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       mem_ack,
    output seq_state_e state,
    output logic       accept,
    output logic       rd_ack,
    output logic       cmp_en,
    output logic       wr_ack
);

    seq_state_e nxt;

    assign accept = (state == ST_IDLE) && req_valid;
    assign rd_ack = (state == ST_RD_WAIT) && mem_ack;
    assign wr_ack = (state == ST_WR_WAIT) && mem_ack;
    assign cmp_en = (state == ST_CMP);

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:    if (req_valid) nxt = ST_RD_REQ;
            ST_RD_REQ:  nxt = ST_RD_WAIT;
            ST_RD_WAIT: if (mem_ack) nxt = ST_CMP;
            ST_CMP:     nxt = ST_WR_REQ;
            ST_WR_REQ:  nxt = ST_WR_WAIT;
            ST_WR_WAIT: if (mem_ack) nxt = ST_DONE;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/dwcas_dp.sv
module dwcas_dp #(
    parameter int HALF_W = 64,
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic                rd_ack,
    input  logic                cmp_en,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [HALF_W-1:0]   exp_lo,
    input  logic [HALF_W-1:0]   exp_hi,
    input  logic [HALF_W-1:0]   des_lo,
    input  logic [HALF_W-1:0]   des_hi,
    input  logic [2*HALF_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0]   addr_q,
    output logic [2*HALF_W-1:0] wdata_q,
    output logic                ok_q,
    output logic [2*HALF_W-1:0] exp_q
);

    localparam int WORD_W = 2 * HALF_W;
    localparam int NHALF  = 2;

    logic [WORD_W-1:0] des_q;
    logic [WORD_W-1:0] obs_q;
    logic [NHALF-1:0]  half_eq;
    logic              all_eq;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        assign half_eq[h] = (obs_q[h*HALF_W +: HALF_W] == exp_q[h*HALF_W +: HALF_W]);
    end

    assign all_eq = &half_eq;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            exp_q   <= '0;
            des_q   <= '0;
            obs_q   <= '0;
            wdata_q <= '0;
            ok_q    <= 1'b0;
        end else begin
            if (accept) begin
                addr_q <= req_addr;
                exp_q  <= {exp_hi, exp_lo};
                des_q  <= {des_hi, des_lo};
            end
            if (rd_ack) begin
                obs_q <= mem_rdata;
            end
            if (cmp_en) begin
                ok_q    <= all_eq;
                wdata_q <= all_eq ? des_q : obs_q;
                if (!all_eq) exp_q <= obs_q;
            end
        end
    end

endmodule

// File: rtl/dwcas_lock.sv
module dwcas_lock (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic req_lock,
    input  logic wr_ack,
    output logic lock_q
);

    always_ff @(posedge clk) begin
        if (rst)                      lock_q <= 1'b0;
        else if (accept && req_lock)  lock_q <= 1'b1;
        else if (wr_ack)              lock_q <= 1'b0;
    end

endmodule

// File: rtl/dwcas_seq.sv
module dwcas_seq
    import dwcas_pkg::*;
#(
    parameter int HALF_W = 64,
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_lock,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [HALF_W-1:0]   exp_lo,
    input  logic [HALF_W-1:0]   exp_hi,
    input  logic [HALF_W-1:0]   des_lo,
    input  logic [HALF_W-1:0]   des_hi,
    output logic                busy,
    output logic                done,
    output logic                success,
    output logic [HALF_W-1:0]   exp_lo_q,
    output logic [HALF_W-1:0]   exp_hi_q,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_rd_req,
    output logic                mem_wr_req,
    output logic [2*HALF_W-1:0] mem_wdata,
    input  logic [2*HALF_W-1:0] mem_rdata,
    input  logic                mem_ack,
    output logic                mem_lock
);

    localparam int WORD_W = 2 * HALF_W;

    seq_state_e        state;
    logic              accept, rd_ack, cmp_en, wr_ack;
    logic [WORD_W-1:0] exp_q;

    dwcas_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .mem_ack   (mem_ack),
        .state     (state),
        .accept    (accept),
        .rd_ack    (rd_ack),
        .cmp_en    (cmp_en),
        .wr_ack    (wr_ack)
    );

    dwcas_dp #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .rd_ack    (rd_ack),
        .cmp_en    (cmp_en),
        .req_addr  (req_addr),
        .exp_lo    (exp_lo),
        .exp_hi    (exp_hi),
        .des_lo    (des_lo),
        .des_hi    (des_hi),
        .mem_rdata (mem_rdata),
        .addr_q    (mem_addr),
        .wdata_q   (mem_wdata),
        .ok_q      (success),
        .exp_q     (exp_q)
    );

    dwcas_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .req_lock (req_lock),
        .wr_ack   (wr_ack),
        .lock_q   (mem_lock)
    );

    assign busy       = (state != ST_IDLE);
    assign done       = (state == ST_DONE);
    assign mem_rd_req = in_read_phase(state);
    assign mem_wr_req = in_write_phase(state);
    assign exp_lo_q   = exp_q[HALF_W-1:0];
    assign exp_hi_q   = exp_q[WORD_W-1:HALF_W];

endmodule

// File: rtl/dwcas_seq_chk.sv
module dwcas_seq_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_lock,
    input logic busy,
    input logic done,
    input logic mem_rd_req,
    input logic mem_wr_req,
    input logic mem_ack,
    input logic mem_lock
);

    logic op_locked;

    always_ff @(posedge clk) begin
        if (rst)                     op_locked <= 1'b0;
        else if (req_valid && !busy) op_locked <= req_lock;
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(mem_rd_req || mem_wr_req || mem_lock));

    a_r3_no_dual_req: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_req && mem_wr_req));

    a_r3_rd_held: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_ack) |=> mem_rd_req);

    a_r6_wr_held: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_req && !mem_ack) |=> mem_wr_req);

    a_r7_lock_on_read: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> (mem_lock == op_locked));

    a_r7_lock_on_write: assert property (@(posedge clk) disable iff (rst)
        mem_wr_req |-> (mem_lock == op_locked));

    a_r7_lock_release: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_req && mem_ack) |=> !mem_lock);

    a_r8_lock_in_op: assert property (@(posedge clk) disable iff (rst)
        mem_lock |-> busy);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

endmodule

bind dwcas_seq dwcas_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_lock   (req_lock),
    .busy       (busy),
    .done       (done),
    .mem_rd_req (mem_rd_req),
    .mem_wr_req (mem_wr_req),
    .mem_ack    (mem_ack),
    .mem_lock   (mem_lock)
);

// File: tb/dwcas_seq_tb.sv
module dwcas_seq_tb;

    localparam int HALF_W = 64;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 2 * HALF_W;
    localparam int NLOC   = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_lock = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [HALF_W-1:0] exp_lo = '0, exp_hi = '0, des_lo = '0, des_hi = '0;
    logic              busy, done, success;
    logic [HALF_W-1:0] exp_lo_q, exp_hi_q;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rd_req, mem_wr_req, mem_lock;
    logic [WORD_W-1:0] mem_wdata;
    logic [WORD_W-1:0] mem_rdata = '0;
    logic              mem_ack = 1'b0;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dwcas_seq #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_lock(req_lock),
        .req_addr(req_addr), .exp_lo(exp_lo), .exp_hi(exp_hi),
        .des_lo(des_lo), .des_hi(des_hi), .busy(busy), .done(done),
        .success(success), .exp_lo_q(exp_lo_q), .exp_hi_q(exp_hi_q),
        .mem_addr(mem_addr), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_lock(mem_lock)
    );

    // memory model
    logic [WORD_W-1:0] model_mem [NLOC];
    logic [WORD_W-1:0] ref_mem   [NLOC];
    int lat = 0;
    int wr_count = 0;
    int rd_count = 0;
    logic [ADDR_W-1:0] last_wr_addr = '0;

    always @(posedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
            if (mem_wr_req) begin
                model_mem[mem_addr[3:0]] <= mem_wdata;
                wr_count <= wr_count + 1;
                last_wr_addr <= mem_addr;
            end else if (mem_rd_req) begin
                rd_count <= rd_count + 1;
            end
        end else if (mem_rd_req || mem_wr_req) begin
            if (lat == 0) begin
                mem_ack   <= 1'b1;
                mem_rdata <= model_mem[mem_addr[3:0]];
                lat       <= int'($urandom % 3);
            end else begin
                lat <= lat - 1;
            end
        end
    end

    // lock monitor
    bit mon_on = 0;
    bit cur_lock = 0;
    int lock_cycles = 0;
    int lock_bad = 0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (mem_lock) lock_cycles++;
            if ((mem_rd_req || mem_wr_req) && (mem_lock != cur_lock)) lock_bad++;
        end
    end

    function automatic logic [WORD_W-1:0] pick_write(logic [WORD_W-1:0] old,
                                                     logic [WORD_W-1:0] expv,
                                                     logic [WORD_W-1:0] desv);
        return (old == expv) ? desv : old;
    endfunction

    task automatic check(bit cond, string req, logic [WORD_W-1:0] act,
                         logic [WORD_W-1:0] expv, string what);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic run_op(logic [3:0] idx, logic [WORD_W-1:0] expv,
                          logic [WORD_W-1:0] desv, bit lk, bit intrude);
        logic [WORD_W-1:0] old;
        logic [WORD_W-1:0] other_before;
        bit want_ok;
        int wr_before, rd_before, waited;
        logic [3:0] other;
        old = ref_mem[idx];
        other = idx + 4'd1;
        other_before = ref_mem[other];
        want_ok = (old == expv);
        wr_before = wr_count;
        rd_before = rd_count;
        lock_cycles = 0;
        lock_bad = 0;
        cur_lock = lk;
        @(negedge clk);
        req_valid = 1'b1;
        req_lock = lk;
        req_addr = {{(ADDR_W-4){1'b0}}, idx};
        {exp_hi, exp_lo} = expv;
        {des_hi, des_lo} = desv;
        mon_on = 1;
        @(negedge clk);
        check(busy == 1'b1, "R9", {127'd0, busy}, 128'd1, "busy after accept");
        if (intrude) begin
            req_addr = {{(ADDR_W-4){1'b0}}, other};
            req_lock = ~lk;
            {des_hi, des_lo} = ~desv;
            repeat (2) @(negedge clk);
        end
        req_valid = 1'b0;
        waited = 0;
        while (!done && waited < 60) begin
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1, "R9", {127'd0, done}, 128'd1, "done reached");
        check(success == want_ok, want_ok ? "R4" : "R5", {127'd0, success},
              {127'd0, want_ok}, "success flag");
        check({exp_hi_q, exp_lo_q} == old, want_ok ? "R11" : "R5",
              {exp_hi_q, exp_lo_q}, old, "expected register");
        check(mem_lock == 1'b0, "R7", {127'd0, mem_lock}, 128'd0, "lock low after write ack");
        check(wr_count == wr_before + 1 && last_wr_addr[3:0] == idx, "R6",
              WORD_W'(wr_count - wr_before), 128'd1, "one write to target");
        check(rd_count == rd_before + 1, "R3", WORD_W'(rd_count - rd_before), 128'd1,
              "one read");
        ref_mem[idx] = pick_write(old, expv, desv);
        check(model_mem[idx] == ref_mem[idx], want_ok ? "R4" : "R5",
              model_mem[idx], ref_mem[idx], "memory after write");
        if (lk) begin
            check(lock_bad == 0 && lock_cycles > 0, "R7", WORD_W'(lock_bad), 128'd0,
                  "lock held over read and write");
        end else begin
            check(lock_cycles == 0, "R8", WORD_W'(lock_cycles), 128'd0,
                  "no lock on unlocked op");
        end
        @(negedge clk);
        mon_on = 0;
        check(done == 1'b0, "R9", {127'd0, done}, 128'd0, "done one cycle");
        if (intrude) begin
            check(model_mem[other] == other_before && busy == 1'b0, "R2",
                  model_mem[other], other_before, "busy request ignored");
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            tests++;
            $display("FAIL watchdog expired: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NLOC; i++) begin
            model_mem[i] = {32'hA5A5_0000 + 32'(i), 32'h1111_0000 + 32'(i),
                            32'h5A5A_0000 + 32'(i), 32'h2222_0000 + 32'(i)};
            ref_mem[i] = model_mem[i];
        end
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_rd_req && !mem_wr_req && !mem_lock, "R1",
              {123'd0, busy, done, mem_rd_req, mem_wr_req, mem_lock}, 128'd0,
              "outputs during reset");
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !mem_lock, "R1", {126'd0, busy, mem_lock}, 128'd0, "idle after reset");

        // directed: locked success, unlocked failure
        run_op(4'd2, ref_mem[2], 128'hDEAD_BEEF_0000_0001_CAFE_F00D_0000_0002, 1'b1, 1'b0);
        run_op(4'd3, ~ref_mem[3], 128'h1, 1'b0, 1'b0);
        // R10: only high half differs, only low half differs
        run_op(4'd5, ref_mem[5] ^ {64'h1, 64'h0}, 128'h77, 1'b1, 1'b0);
        run_op(4'd6, ref_mem[6] ^ {64'h0, 64'h8000_0000_0000_0000}, 128'h88, 1'b1, 1'b0);
        // R2: request while busy
        run_op(4'd8, ref_mem[8], 128'h99, 1'b1, 1'b1);
        run_op(4'd9, ~ref_mem[9], 128'hAA, 1'b0, 1'b1);

        // constrained random
        for (int n = 0; n < 60; n++) begin
            logic [3:0] idx;
            logic [WORD_W-1:0] e, d;
            idx = 4'($urandom % 4);
            d = {$urandom, $urandom, $urandom, $urandom};
            case ($urandom % 4)
                0, 1: e = ref_mem[idx];
                2:    e = ref_mem[idx] ^ (WORD_W'(1) << ($urandom % WORD_W));
                default: e = {$urandom, $urandom, $urandom, $urandom};
            endcase
            run_op(idx, e, d, 1'($urandom % 2), 1'($urandom % 8 == 0));
        end

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule